// File: doc/BRIEF.md
# Serial Line Interrupt Scanner

This block sits between a bank of serial line channels and the CPU's interrupt path. Each channel raises level flags when a received character is waiting or when its transmitter has finished a character. A scanner walks the channels, picks the next pending condition, holds it in a small per-type queue and locks onto it. The CPU then reads the locked channel and condition type through a parallel-input port and clears the interrupt. After the clear, the scanner moves on to the receive condition of the next channel. A single channel therefore cannot starve the others, even when it has both conditions pending.

The CPU can also send a parallel-output command to a channel. If that command asks for an interrupt, carries no character and finds the channel's transmitter idle, a transmit interrupt is queued at once. This is how the CPU starts output on a line. The queue holds one entry per condition type. When the transmit entry is already taken, the request is kept as a sticky per-channel kick, and the scanner picks it up later, so it is never lost.

Top module: `mux_int_scanner`

## Requirements
- R1: After reset, `irq_o` is low and `pin_o` reads all zeros.
- R2: While no interrupt is locked, `pin_o` reads all zeros (not ready). While an interrupt is locked, `irq_o` is high and `pin_o` reads {1, type, channel}, where type 0 means receive and type 1 means transmit, and channel sits in the low bits.
- R3: When the scanner reaches a channel, it tests the receive condition before the transmit condition. If both are pending on the same channel, receive is presented first.
- R4: After an interrupt is found on a channel, the scan resumes at the receive condition of the next channel. A channel's remaining condition is presented only after every other channel has been visited.
- R5: A locked interrupt keeps `irq_o` high and `pin_o` unchanged until `irq_clr_i` is asserted. The cycle after a clear, `irq_o` is low.
- R6: A parallel-output command with the interrupt-request bit set, no character present, and an idle transmitter on the addressed channel queues a transmit interrupt for that channel at once. This entry is presented before the scanner resumes.
- R7: At most one transmit interrupt and one receive interrupt are queued at a time. A self-start request that finds the transmit entry taken is deferred, not dropped, and the scanner presents it in round-robin order.
- R8: A parallel-output command that carries a character, lacks the interrupt-request bit, or addresses a busy transmitter raises no interrupt.
- R9: Clearing a self-started transmit interrupt retires the request, and it is not raised again.
- R10: The scan pointer wraps from the last channel back to channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_rdy_i | input | NCH | Per-channel received-character-waiting flag (level) |
| tx_done_i | input | NCH | Per-channel transmit-complete flag (level) |
| tx_busy_i | input | NCH | Per-channel transmitter-active flag |
| pot_vld_i | input | 1 | Parallel-output command strobe |
| pot_ch_i | input | CW | Channel addressed by the command |
| pot_irq_i | input | 1 | Command requests an interrupt |
| pot_chr_i | input | 1 | Command carries a transmit character |
| irq_clr_i | input | 1 | CPU clears the locked interrupt |
| irq_o | output | 1 | Interrupt request to the CPU |
| pin_o | output | CW+2 | Parallel-input read value {ready, type, channel} |

## Verification
The assertions assume that `irq_clr_i` is raised only while an interrupt is locked. They also assume that a channel's flag is lowered by the servicing agent before the interrupt for it is cleared, so one level is not reported twice. The bench follows both rules. Its servicing process drops the flag of the presented condition first and then pulses the clear for one cycle. All new flags for ordering tests are raised while an interrupt is held locked, so the scan position after the clear is known and the expected order is fixed.

// File: rtl/mis_pkg.sv
package mis_pkg;
  typedef enum logic {
    FLG_RX = 1'b0,
    FLG_TX = 1'b1
  } flag_t;
endpackage

// File: rtl/mis_scan_ptr.sv
module mis_scan_ptr
  import mis_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en_i,
  input  logic          hit_i,
  output logic [CW-1:0] ch_o,
  output flag_t         t_o
);
  localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);

  logic [CW-1:0] ch_q, ch_d, ch_inc;
  flag_t         t_q, t_d;

  assign ch_inc = (ch_q == LAST_CH) ? '0 : ch_q + 1'b1;

  always_comb begin
    ch_d = ch_q;
    t_d  = t_q;
    if (hit_i) begin
      ch_d = ch_inc;
      t_d  = FLG_RX;
    end else if (t_q == FLG_RX) begin
      t_d  = FLG_TX;
    end else begin
      ch_d = ch_inc;
      t_d  = FLG_RX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q <= '0;
      t_q  <= FLG_RX;
    end else if (step_en_i) begin
      ch_q <= ch_d;
      t_q  <= t_d;
    end
  end

  assign ch_o = ch_q;
  assign t_o  = t_q;
endmodule

// File: rtl/mis_kick.sv
module mis_kick #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] kick_o
);
  logic [NCH-1:0] kick_q, kick_d;

  for (genvar g = 0; g < NCH; g++) begin : g_kick
    always_comb begin
      kick_d[g] = kick_q[g];
      if (clr_i[g]) kick_d[g] = 1'b0;
      if (set_i[g]) kick_d[g] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kick_q <= '0;
    else        kick_q <= kick_d;
  end

  assign kick_o = kick_q;
endmodule

// File: rtl/mis_irq_queue.sv
module mis_irq_queue
  import mis_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_fill_i,
  input  flag_t         scan_t_i,
  input  logic [CW-1:0] scan_ch_i,
  input  logic          pot_fill_i,
  input  logic [CW-1:0] pot_ch_i,
  input  logic          clr_i,
  output logic          lock_v_o,
  output flag_t         lock_t_o,
  output logic [CW-1:0] lock_ch_o,
  output logic          q_any_o,
  output logic          tx_slot_full_o
);
  logic [1:0]    qv_q, qv_d;
  logic [CW-1:0] qch_q [2];
  logic [CW-1:0] qch_d [2];
  flag_t         first_q, first_d;
  logic          lock_v_q, lock_v_d;
  flag_t         lock_t_q, lock_t_d;
  logic          clr_fire;

  assign clr_fire = lock_v_q & clr_i;

  always_comb begin
    qv_d     = qv_q;
    qch_d[0] = qch_q[0];
    qch_d[1] = qch_q[1];
    first_d  = first_q;
    if (clr_fire) begin
      qv_d[lock_t_q] = 1'b0;
      first_d        = (lock_t_q == FLG_RX) ? FLG_TX : FLG_RX;
    end
    if (scan_fill_i) begin
      if (!qv_d[~scan_t_i]) first_d = scan_t_i;
      qv_d[scan_t_i]  = 1'b1;
      qch_d[scan_t_i] = scan_ch_i;
    end
    if (pot_fill_i) begin
      if (!qv_d[FLG_RX]) first_d = FLG_TX;
      qv_d[FLG_TX]  = 1'b1;
      qch_d[FLG_TX] = pot_ch_i;
    end
  end

  always_comb begin
    lock_v_d = lock_v_q;
    lock_t_d = lock_t_q;
    if (clr_fire) begin
      lock_v_d = 1'b0;
    end else if (!lock_v_q && (qv_q != 2'b00)) begin
      lock_v_d = 1'b1;
      if (qv_q == 2'b11)    lock_t_d = first_q;
      else if (qv_q[FLG_TX]) lock_t_d = FLG_TX;
      else                   lock_t_d = FLG_RX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qv_q     <= '0;
      qch_q[0] <= '0;
      qch_q[1] <= '0;
      first_q  <= FLG_RX;
      lock_v_q <= 1'b0;
      lock_t_q <= FLG_RX;
    end else begin
      qv_q     <= qv_d;
      qch_q[0] <= qch_d[0];
      qch_q[1] <= qch_d[1];
      first_q  <= first_d;
      lock_v_q <= lock_v_d;
      lock_t_q <= lock_t_d;
    end
  end

  assign lock_v_o       = lock_v_q;
  assign lock_t_o       = lock_t_q;
  assign lock_ch_o      = qch_q[lock_t_q];
  assign q_any_o        = |qv_q;
  assign tx_slot_full_o = qv_q[FLG_TX];
endmodule

// File: rtl/mux_int_scanner.sv
module mux_int_scanner
  import mis_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rx_rdy_i,
  input  logic [NCH-1:0] tx_done_i,
  input  logic [NCH-1:0] tx_busy_i,
  input  logic           pot_vld_i,
  input  logic [CW-1:0]  pot_ch_i,
  input  logic           pot_irq_i,
  input  logic           pot_chr_i,
  input  logic           irq_clr_i,
  output logic           irq_o,
  output logic [CW+1:0]  pin_o
);
  logic [CW-1:0]  ptr_ch;
  flag_t          ptr_t;
  logic           lock_v, q_any, tx_full;
  flag_t          lock_t;
  logic [CW-1:0]  lock_ch;
  logic [NCH-1:0] kick, kick_set, kick_clr, tx_cond;
  logic           step_en, cond_here, hit;
  logic           pot_ok, pot_start, pot_fill;

  assign tx_cond = tx_done_i | kick;

  // scanner runs only while nothing is locked or waiting to lock
  assign step_en   = !lock_v && !q_any;
  assign cond_here = (ptr_t == FLG_RX) ? rx_rdy_i[ptr_ch] : tx_cond[ptr_ch];

  assign pot_ok    = (int'(pot_ch_i) < NCH);
  assign pot_start = pot_vld_i && pot_irq_i && !pot_chr_i && pot_ok &&
                     !tx_busy_i[pot_ch_i];
  assign pot_fill  = pot_start && !tx_full;

  assign hit = step_en && cond_here && !((ptr_t == FLG_TX) && pot_fill);

  for (genvar g = 0; g < NCH; g++) begin : g_kick_ctl
    assign kick_set[g] = pot_start && tx_full && (int'(pot_ch_i) == g);
    assign kick_clr[g] = lock_v && irq_clr_i && (lock_t == FLG_TX) &&
                         (int'(lock_ch) == g);
  end

  mis_scan_ptr #(.NCH(NCH)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en_i (step_en),
    .hit_i     (hit),
    .ch_o      (ptr_ch),
    .t_o       (ptr_t)
  );

  mis_kick #(.NCH(NCH)) u_kick (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (kick_set),
    .clr_i  (kick_clr),
    .kick_o (kick)
  );

  mis_irq_queue #(.NCH(NCH)) u_queue (
    .clk            (clk),
    .rst_n          (rst_n),
    .scan_fill_i    (hit),
    .scan_t_i       (ptr_t),
    .scan_ch_i      (ptr_ch),
    .pot_fill_i     (pot_fill),
    .pot_ch_i       (pot_ch_i),
    .clr_i          (irq_clr_i),
    .lock_v_o       (lock_v),
    .lock_t_o       (lock_t),
    .lock_ch_o      (lock_ch),
    .q_any_o        (q_any),
    .tx_slot_full_o (tx_full)
  );

  assign irq_o = lock_v;
  assign pin_o = lock_v ? {1'b1, lock_t, lock_ch} : '0;
endmodule

// File: rtl/mis_scan_chk.sv
module mis_scan_chk #(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] tx_busy_i,
  input logic           pot_vld_i,
  input logic [CW-1:0]  pot_ch_i,
  input logic           pot_irq_i,
  input logic           pot_chr_i,
  input logic           irq_clr_i,
  input logic           irq_o,
  input logic [CW+1:0]  pin_o
);
  logic self_start;
  assign self_start = pot_vld_i && pot_irq_i && !pot_chr_i &&
                      (int'(pot_ch_i) < NCH) && !tx_busy_i[pot_ch_i];

  p_idle_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (pin_o == '0));

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> (irq_o && $stable(pin_o)));

  p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_clr_i) |=> !irq_o);

  p_self_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (self_start && !irq_o) |=> ##1 irq_o);

  p_ready_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> pin_o[CW+1]);
endmodule

bind mux_int_scanner mis_scan_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_busy_i (tx_busy_i),
  .pot_vld_i (pot_vld_i),
  .pot_ch_i  (pot_ch_i),
  .pot_irq_i (pot_irq_i),
  .pot_chr_i (pot_chr_i),
  .irq_clr_i (irq_clr_i),
  .irq_o     (irq_o),
  .pin_o     (pin_o)
);

// File: tb/sim_mux_int_scanner.sv
module sim_mux_int_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int CW = 3;
  localparam int WATCHDOG = 20000;

  logic           clk, rst_n;
  logic [NCH-1:0] rx_rdy, tx_done, tx_busy;
  logic           pot_vld, pot_irq, pot_chr, irq_clr;
  logic [CW-1:0]  pot_ch;
  logic           irq;
  logic [CW+1:0]  pin;

  int checks = 0, failures = 0;
  logic hold = 1'b0;
  logic done = 1'b0;
  logic [CW+1:0] exp_q [$];

  mux_int_scanner #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_rdy_i(rx_rdy), .tx_done_i(tx_done),
    .tx_busy_i(tx_busy), .pot_vld_i(pot_vld), .pot_ch_i(pot_ch),
    .pot_irq_i(pot_irq), .pot_chr_i(pot_chr), .irq_clr_i(irq_clr),
    .irq_o(irq), .pin_o(pin)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // type 0 = receive, 1 = transmit
  task automatic expect_irq(input int ch, input bit t);
    exp_q.push_back({1'b1, t, CW'(ch)});
  endtask

  task automatic pot_cmd(input int ch, input bit rq, input bit chr);
    @(negedge clk);
    pot_vld = 1'b1; pot_ch = CW'(ch); pot_irq = rq; pot_chr = chr;
    @(negedge clk);
    pot_vld = 1'b0; pot_irq = 1'b0; pot_chr = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || irq) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor / servicing agent
  initial begin
    irq_clr = 1'b0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (irq) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected interrupt", 32'(pin), 32'h0);
        end else begin
          logic [CW+1:0] e;
          e = exp_q.pop_front();
          check("R3/R4/R6/R7 presentation order", 32'(pin), 32'(e));
        end
        while (hold) @(negedge clk);
        if (pin[CW] == 1'b0) rx_rdy[pin[CW-1:0]] = 1'b0;
        else                 tx_done[pin[CW-1:0]] = 1'b0;
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R5 clear drops irq", 32'(irq), 32'h0);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG && !done) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; rx_rdy = '0; tx_done = '0; tx_busy = '0;
    pot_vld = 1'b0; pot_ch = '0; pot_irq = 1'b0; pot_chr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 irq after reset", 32'(irq), 32'h0);
    check("R1 pin after reset", 32'(pin), 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 pin not ready while idle", 32'(pin), 32'h0);

    // single receive condition
    expect_irq(2, 1'b0);
    rx_rdy[2] = 1'b1;
    drain();

    // R3 R4 R10: flags raised while (0,RX) is locked
    hold = 1'b1;
    expect_irq(0, 1'b0);
    rx_rdy[0] = 1'b1;
    while (!irq) @(negedge clk);
    tx_done[0] = 1'b1; rx_rdy[1] = 1'b1;
    rx_rdy[2] = 1'b1; tx_done[2] = 1'b1; rx_rdy[7] = 1'b1;
    begin
      logic [CW+1:0] held;
      held = pin;
      repeat (6) @(negedge clk);
      check("R5 lock stable without clear", 32'(pin), 32'(held));
      check("R5 irq held", 32'(irq), 32'h1);
    end
    expect_irq(1, 1'b0);
    expect_irq(2, 1'b0);
    expect_irq(7, 1'b0);
    expect_irq(0, 1'b1);
    expect_irq(2, 1'b1);
    hold = 1'b0;
    drain();

    // R6 R7: self-start while locked on (1,RX)
    hold = 1'b1;
    expect_irq(1, 1'b0);
    rx_rdy[1] = 1'b1;
    while (!irq) @(negedge clk);
    pot_cmd(6, 1'b1, 1'b0);
    pot_cmd(3, 1'b1, 1'b0);
    rx_rdy[2] = 1'b1;
    expect_irq(6, 1'b1);
    expect_irq(2, 1'b0);
    expect_irq(3, 1'b1);
    hold = 1'b0;
    drain();

    // R6 from idle: presented promptly
    expect_irq(5, 1'b1);
    pot_cmd(5, 1'b1, 1'b0);
    @(negedge clk);
    check("R6 self-start raises irq at once", 32'(irq), 32'h1);
    drain();

    // R8 R9: no interrupt expected from these
    tx_busy[4] = 1'b1;
    pot_cmd(4, 1'b1, 1'b0);
    pot_cmd(6, 1'b1, 1'b1);
    pot_cmd(1, 1'b0, 1'b0);
    begin
      int seen = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (irq) seen++;
      end
      check("R8 R9 no interrupt raised", 32'(seen), 32'h0);
    end
    check("R2 pin not ready after quiet window", 32'(pin), 32'h0);
    tx_busy[4] = 1'b0;
    drain();
    check("R7 every queued item presented", 32'(exp_q.size()), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule